// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog peripheral on a simple 32-bit register bus with APB-style select and enable phases. A down-counter runs from a programmable reload value. When it reaches zero for the first time, it raises an interrupt and starts counting again from the reload value. If software has still not cleared that interrupt when the second countdown ends, and the reset path is enabled, the block asserts a system reset. That reset stays asserted until the block itself is reset.

Software services the watchdog in one of two ways: by writing the interrupt-clear register, or by rewriting the reload value. Either write restarts the count at once. Every write is refused while the block is locked, except a write to the lock register. Writing a 32-bit key to the lock register opens write access, and writing any other value to it closes write access again. The block leaves reset locked, so a stray write cannot stop or retune a running watchdog.

Top module: `wdog_lockable`

## Requirements
- R1: After reset, the reload register and the count both read 0xFFFFFFFF, control reads 0, the lock register reads 1, and both `irq_o` and `wdog_rst_o` are 0.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and the lock register then reads 0 in bit 0. Writing any other value there locks the block, and it then reads 1. A lock write is accepted in either state.
- R3: While the block is locked, writes to offsets 0x000, 0x008 and 0x00C have no effect.
- R4: The count at offset 0x004 decrements by one each clock only while control bit 0 (offset 0x008) is set, and holds while that bit is clear. Control bit 1 enables the reset output. Both bits read back.
- R5: When the running count is 0, the next clock reloads it from the reload register. If the raw status bit (offset 0x010, bit 0) is clear, that clock also sets it.
- R6: If the raw status bit is already set when the running count reaches 0, and control bit 1 is set, `wdog_rst_o` asserts on the next clock and stays asserted until `rst`. With control bit 1 clear, it does not assert.
- R7: A write of any value to offset 0x00C clears the raw status bit and reloads the count from the reload register.
- R8: A write to offset 0x000 stores the value, with 0 stored as 1, and loads that value into the count on the same clock. Rewriting it periodically therefore prevents any expiry.
- R9: The masked status at offset 0x014, bit 0, and `irq_o` both equal the raw status AND control bit 0.
- R10: Offset 0xFE0 reads the fixed identification word (parameter `ID_WORD`, default 0x0057D061).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, captured in the setup phase and valid in the access phase |
| irq_o | output | 1 | Masked interrupt |
| wdog_rst_o | output | 1 | Sticky system reset request |

## Verification
The bench runs the counter with the reset path disabled through two expiries, which separates the interrupt stage from the reset stage. It then repeats this with the reset path enabled and the interrupt left pending, which must give a reset. A run that rewrites the reload value faster than it can expire must never raise the interrupt, and this shows that a reload write restarts the count. Writes made while the block is locked are read back, and the reset output is watched after relocking, to show that locked writes change nothing. A behavioural model checks the interrupt, the reset output and every read on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [11:0] OFS_LOAD  = 12'h000;
  localparam logic [11:0] OFS_VALUE = 12'h004;
  localparam logic [11:0] OFS_CTRL  = 12'h008;
  localparam logic [11:0] OFS_ICLR  = 12'h00C;
  localparam logic [11:0] OFS_RIS   = 12'h010;
  localparam logic [11:0] OFS_MIS   = 12'h014;
  localparam logic [11:0] OFS_LOCK  = 12'hC00;
  localparam logic [11:0] OFS_ID    = 12'hFE0;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic rst_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [DATA_W-1:0] ID_WORD = 32'h0057D061
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              ris_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic [DATA_W-1:0] reload_val_o,
  output logic              reload_o,
  output logic              clr_o,
  output ctrl_t             ctrl_o
);
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

  logic              locked_q;
  logic [DATA_W-1:0] load_q;
  ctrl_t             ctrl_q;
  logic              wr, open_wr;
  logic              wr_load, wr_ctrl, wr_iclr, wr_lock;
  logic [DATA_W-1:0] wdata_clamped;
  logic [DATA_W-1:0] rd_mux;

  assign wr      = psel && penable && pwrite;
  assign open_wr = wr && !locked_q;
  assign wr_load = open_wr && (paddr == ADDR_W'(OFS_LOAD));
  assign wr_ctrl = open_wr && (paddr == ADDR_W'(OFS_CTRL));
  assign wr_iclr = open_wr && (paddr == ADDR_W'(OFS_ICLR));
  assign wr_lock = wr && (paddr == ADDR_W'(OFS_LOCK));

  assign wdata_clamped = (pwdata == '0) ? ONE : pwdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b1;
      load_q   <= ALL_ONES;
      ctrl_q   <= '0;
    end else begin
      if (wr_lock) locked_q <= (pwdata != UNLOCK_KEY);
      if (wr_load) load_q   <= wdata_clamped;
      if (wr_ctrl) ctrl_q   <= ctrl_t'(pwdata[1:0]);
    end
  end

  assign reload_val_o = wr_load ? wdata_clamped : load_q;
  assign reload_o     = wr_load || wr_iclr;
  assign clr_o        = wr_iclr;
  assign ctrl_o       = ctrl_q;

  always_comb begin
    rd_mux = '0;
    unique case (paddr)
      ADDR_W'(OFS_LOAD):  rd_mux = load_q;
      ADDR_W'(OFS_VALUE): rd_mux = cnt_i;
      ADDR_W'(OFS_CTRL):  rd_mux = {{(DATA_W-2){1'b0}}, ctrl_q};
      ADDR_W'(OFS_RIS):   rd_mux = {{(DATA_W-1){1'b0}}, ris_i};
      ADDR_W'(OFS_MIS):   rd_mux = {{(DATA_W-1){1'b0}}, ris_i & ctrl_q.run};
      ADDR_W'(OFS_LOCK):  rd_mux = {{(DATA_W-1){1'b0}}, locked_q};
      ADDR_W'(OFS_ID):    rd_mux = ID_WORD;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prdata_o <= '0;
    else if (psel && !penable && !pwrite) prdata_o <= rd_mux;
  end

  p_locked_ctrl_r3: assert property (@(posedge clk) disable iff (rst)
    (locked_q && wr && paddr == ADDR_W'(OFS_CTRL)) |=> $stable(ctrl_q));
  p_locked_load_r3: assert property (@(posedge clk) disable iff (rst)
    (locked_q && wr && paddr == ADDR_W'(OFS_LOAD)) |=> $stable(load_q));
  p_load_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    load_q != '0);
  p_key_unlocks_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_lock && pwdata == UNLOCK_KEY) |=> !locked_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl_i,
  input  logic              reload_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] reload_val_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              ris_o,
  output logic              sysrst_o
);
  logic expire;
  assign expire = ctrl_i.run && (cnt_o == '0) && !reload_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o    <= {DATA_W{1'b1}};
      ris_o    <= 1'b0;
      sysrst_o <= 1'b0;
    end else begin
      if (clr_i) ris_o <= 1'b0;
      if (reload_i) begin
        cnt_o <= reload_val_i;
      end else if (ctrl_i.run) begin
        if (cnt_o == '0) cnt_o <= reload_val_i;
        else             cnt_o <= cnt_o - 1'b1;
      end
      if (expire) begin
        if (!ris_o)             ris_o    <= 1'b1;
        else if (ctrl_i.rst_en) sysrst_o <= 1'b1;
      end
    end
  end

  p_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i.run && !reload_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_i.run && !reload_i) |=> $stable(cnt_o));
  p_first_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i.run && !reload_i && cnt_o == '0) |=> ris_o);
  p_rst_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    sysrst_o |=> sysrst_o);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !ris_o);
endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [DATA_W-1:0] ID_WORD = 32'h0057D061
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq_o,
  output logic              wdog_rst_o
);
  logic [DATA_W-1:0] cnt, reload_val;
  logic              ris, reload, clr;
  ctrl_t             ctrl;

  wdog_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_WORD(ID_WORD)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .cnt_i(cnt), .ris_i(ris),
    .prdata_o(prdata), .reload_val_o(reload_val), .reload_o(reload),
    .clr_o(clr), .ctrl_o(ctrl)
  );

  wdog_counter #(.DATA_W(DATA_W)) u_counter (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .reload_i(reload), .clr_i(clr),
    .reload_val_i(reload_val), .cnt_o(cnt), .ris_o(ris), .sysrst_o(wdog_rst_o)
  );

  assign irq_o = ris & ctrl.run;
endmodule

// File: tb/wdog_lockable_bench.sv
module wdog_lockable_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq_o, wdog_rst_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] rd;

  wdog_lockable u_wdog_lockable (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o),
    .wdog_rst_o(wdog_rst_o)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  logic [31:0] m_load, m_cnt, m_rdata;
  logic [1:0]  m_ctrl;
  bit          m_ris, m_rst, m_locked;

  always @(posedge clk) begin
    bit we;
    logic [31:0] nv;
    if (rst) begin
      m_load = 32'hFFFFFFFF; m_cnt = 32'hFFFFFFFF; m_ctrl = 0;
      m_ris = 0; m_rst = 0; m_locked = 1; m_rdata = 0;
    end else begin
      if (psel && !penable && !pwrite) begin
        case (paddr)
          12'h000: m_rdata = m_load;
          12'h004: m_rdata = m_cnt;
          12'h008: m_rdata = {30'd0, m_ctrl};
          12'h010: m_rdata = {31'd0, m_ris};
          12'h014: m_rdata = {31'd0, m_ris & m_ctrl[0]};
          12'hC00: m_rdata = {31'd0, m_locked};
          12'hFE0: m_rdata = 32'h0057D061;
          default: m_rdata = 0;
        endcase
      end
      we = psel && penable && pwrite;
      if (we && paddr == 12'h000 && !m_locked) begin
        nv = (pwdata == 0) ? 32'd1 : pwdata;
        m_load = nv; m_cnt = nv;
      end else if (we && paddr == 12'h00C && !m_locked) begin
        m_ris = 0; m_cnt = m_load;
      end else if (m_ctrl[0]) begin
        if (m_cnt == 0) begin
          m_cnt = m_load;
          if (!m_ris) m_ris = 1;
          else if (m_ctrl[1]) m_rst = 1;
        end else m_cnt = m_cnt - 1;
      end
      if (we && paddr == 12'h008 && !m_locked) m_ctrl = pwdata[1:0];
      if (we && paddr == 12'hC00) m_locked = (pwdata != 32'h1ACCE551);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check("R9 irq_o", {31'd0, irq_o}, {31'd0, m_ris & m_ctrl[0]});
      check("R6 wdog_rst_o", {31'd0, wdog_rst_o}, {31'd0, m_rst});
      if (psel && penable && !pwrite) check("R4 readback", prdata, m_rdata);
    end
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rst = 0;
    // R1 reset state
    bus_rd(12'h000, rd); check("R1 load", rd, 32'hFFFFFFFF);
    bus_rd(12'h004, rd); check("R1 count", rd, 32'hFFFFFFFF);
    bus_rd(12'h008, rd); check("R1 ctrl", rd, 0);
    bus_rd(12'hC00, rd); check("R1 lock", rd, 1);
    check("R1 outputs", {30'd0, irq_o, wdog_rst_o}, 0);
    // R3 locked writes ignored
    bus_wr(12'h000, 32'd5);
    bus_wr(12'h008, 32'd3);
    bus_rd(12'h000, rd); check("R3 load locked", rd, 32'hFFFFFFFF);
    bus_rd(12'h008, rd); check("R3 ctrl locked", rd, 0);
    // R2 unlock
    bus_wr(12'hC00, 32'h1ACCE551);
    bus_rd(12'hC00, rd); check("R2 unlocked", rd, 0);
    // R8 load clamp and reload
    bus_wr(12'h000, 32'd0);
    bus_rd(12'h000, rd); check("R8 zero clamps", rd, 1);
    bus_wr(12'h000, 32'd20);
    bus_rd(12'h004, rd); check("R8 count reloaded", rd, 20);
    idle(5);
    bus_rd(12'h004, rd); check("R4 held while stopped", rd, 20);
    // R4/R5 run to first expiry
    bus_wr(12'h008, 32'd1);
    bus_rd(12'h008, rd); check("R4 ctrl readback", rd, 1);
    idle(40);
    bus_rd(12'h010, rd); check("R5 raw set", rd, 1);
    bus_rd(12'h014, rd); check("R9 masked set", rd, 1);
    bus_wr(12'h008, 32'd0);
    bus_rd(12'h014, rd); check("R9 masked off", rd, 0);
    bus_rd(12'h010, rd); check("R9 raw kept", rd, 1);
    // R7 clear
    bus_wr(12'h00C, 32'hDEAD);
    bus_rd(12'h010, rd); check("R7 raw cleared", rd, 0);
    bus_rd(12'h004, rd); check("R7 count reloaded", rd, 20);
    // R6 no reset with bit1 clear
    bus_wr(12'h008, 32'd1);
    idle(60);
    check("R6 no reset when disabled", {31'd0, wdog_rst_o}, 0);
    bus_wr(12'h00C, 32'd0);
    // R8 refresh prevents expiry
    bus_wr(12'h008, 32'd3);
    for (int i = 0; i < 10; i++) begin
      idle(10);
      bus_wr(12'h000, 32'd20);
    end
    bus_rd(12'h010, rd); check("R8 refresh no expiry", rd, 0);
    // R6 two expiries with reset enabled
    idle(60);
    check("R6 reset asserted", {31'd0, wdog_rst_o}, 1);
    // R2 relock, R3 locked write
    bus_wr(12'hC00, 32'h1);
    bus_rd(12'hC00, rd); check("R2 relocked", rd, 1);
    bus_wr(12'h008, 32'd0);
    bus_rd(12'h008, rd); check("R3 ctrl kept", rd, 3);
    bus_wr(12'h00C, 32'd0);
    bus_rd(12'h010, rd); check("R3 clear ignored", rd, 1);
    check("R6 reset sticky", {31'd0, wdog_rst_o}, 1);
    // R10 id word
    bus_rd(12'hFE0, rd); check("R10 id", rd, 32'h0057D061);
    // R1 reset clears everything
    @(negedge clk); rst = 1;
    idle(2);
    rst = 0;
    @(negedge clk);
    check("R1 reset after reset", {31'd0, wdog_rst_o}, 0);
    bus_rd(12'hC00, rd); check("R1 relocked", rd, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule